// File: doc/BRIEF.md
# USB Low/Full-Speed Serial Transmitter

This block drives one USB data pair, at low or full speed, from a stream of bytes. An outside divider supplies a one-cycle bit tick: 12 MHz for full speed (12 Mbit/s) or 1.5 MHz for low speed. The transmitter starts a packet when a byte is offered while it is idle. It first sends the eight-bit sync pattern. It then takes bytes through a valid/ready handshake and shifts them out least-significant bit first, with no gaps between bytes.

Every bit passes through a fixed six-count bit stuffer and an NRZI encoder before it reaches the pins. When no byte is waiting at a byte boundary, the packet closes. The end sequence is two bit times of single-ended zero, one bit time of J, and then the output enable is released. A speed select sets which pin carries the J level. CRC, PID choice and transaction sequencing belong to the caller.

Top module: `usb_serial_tx`

## Requirements
- R1: After reset, oe_o and ready_o are low and the pins show the idle J level.
- R2: A tick that finds valid_i high while idle starts a packet. The following eight bit periods carry the sync word (seven zeros and then a one), which appears on the pair as K J K J K J K K.
- R3: Data bits go out least-significant bit first under NRZI coding: a 0 flips the line between J and K, and a 1 keeps the previous level.
- R4: After six consecutive ones, one extra toggle (a stuffed bit) goes out before the next bit, and the run restarts from zero. The run count carries across the sync-to-data boundary and across byte boundaries.
- R5: The end of a packet is two bit periods with both pins low, then one bit period of J, and then oe_o low. While the enable is asserted, both pins low occurs only during the end of packet.
- R6: ready_o is high for exactly one tick per byte, in the tick that loads that byte's first bit. It is never high in a cycle without a tick, and never high while a stuffed bit is due.
- R7: If valid_i is low at a byte boundary, the packet ends with the end-of-packet sequence. If a stuffed bit is due there, it is sent first.
- R8: With low_speed_i at 0, J is dp_o=1, dm_o=0. With low_speed_i at 1, the pins are swapped: J is dp_o=0, dm_o=1, and K is dp_o=1, dm_o=0.
- R9: The state of the pins and of oe_o changes only in cycles where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle bit-period strobe |
| low_speed_i | input | 1 | 1 selects low-speed pin polarity |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i holds a byte to send |
| ready_o | output | 1 | Byte taken in this cycle |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Drive enable for the pair |

## Verification
The encoder is driven with several kinds of bytes. All-zero bytes toggle on every bit. All-one bytes stuff inside a byte, and the first such stuff depends on the final one of the sync word. Byte pairs such as 0xF0 followed by 0x0F build a run of six ones only across a byte boundary. A byte whose last six bits are ones needs a stuffed bit just before the end of packet. Mixed bytes are sent at both speeds, which separates a correct pin swap from correct coding. Each packet is compared, one bit period at a time, with a line-symbol model built from the requirements. The bench also counts handshakes per byte and watches for any pin change between ticks.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_EOP,
    ST_EOPJ
  } tx_state_e;

  typedef enum logic [2:0] {
    LN_HOLD,
    LN_TOGGLE,
    LN_SE0,
    LN_J,
    LN_OFF
  } line_cmd_e;
endpackage

// File: rtl/usb_tx_stuff.sv
module usb_tx_stuff #(
  parameter int RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clr_i,
  input  logic one_i,
  output logic stuff_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= one_i ? cnt_q + 1'b1 : '0;
  end

  assign stuff_o = (cnt_q == CW'(RUN));

  AST_RUN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_o && step_i && !clr_i) |=> (cnt_q == '0)) else $error("run count kept"); // R4
endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  line_cmd_e cmd_i,
  input  logic      low_speed_i,
  output logic      lvl_o,
  output logic      se0_o,
  output logic      dp_o,
  output logic      dm_o,
  output logic      oe_o
);
  logic lvl_q, se0_q, oe_q;  // lvl_q: 1 = J

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      se0_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (step_i) begin
      unique case (cmd_i)
        LN_TOGGLE: begin lvl_q <= ~lvl_q; se0_q <= 1'b0; oe_q <= 1'b1; end
        LN_HOLD:   begin se0_q <= 1'b0; oe_q <= 1'b1; end
        LN_SE0:    begin se0_q <= 1'b1; oe_q <= 1'b1; end
        LN_J:      begin lvl_q <= 1'b1; se0_q <= 1'b0; oe_q <= 1'b1; end
        LN_OFF:    begin lvl_q <= 1'b1; se0_q <= 1'b0; oe_q <= 1'b0; end
        default:   ;
      endcase
    end
  end

  logic j_dp;
  assign j_dp  = ~low_speed_i;
  assign dp_o  = se0_q ? 1'b0 : (lvl_q ? j_dp : ~j_dp);
  assign dm_o  = se0_q ? 1'b0 : (lvl_q ? ~j_dp : j_dp);
  assign oe_o  = oe_q;
  assign lvl_o = lvl_q;
  assign se0_o = se0_q;

  AST_STEP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable({lvl_q, se0_q, oe_q})) else $error("line moved off tick"); // R9
  AST_SE0_THEN_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(se0_q) |-> (lvl_q && oe_q)) else $error("no J after SE0"); // R5
  AST_SE0_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    se0_q |-> oe_q) else $error("SE0 while released"); // R5
  AST_PAIR_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !se0_q) |-> (dp_o != dm_o)) else $error("pair not differential"); // R8
endmodule

// File: rtl/usb_serial_tx.sv
module usb_serial_tx
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              low_speed_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o
);
  localparam int                IDX_W     = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SYNC_WORD = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;

  logic      ln_step, ln_lvl, ln_se0;
  line_cmd_e ln_cmd;
  logic      st_step, st_clr, st_one, st_stuff;
  logic      emit_bit, bit_val, emit_stuff;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    shreg_d    = shreg_q;
    ready_o    = 1'b0;
    emit_bit   = 1'b0;
    emit_stuff = 1'b0;
    bit_val    = 1'b0;
    st_clr     = 1'b0;
    ln_step    = 1'b0;
    ln_cmd     = LN_HOLD;
    if (tick_i) begin
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          st_clr   = 1'b1;
          emit_bit = 1'b1;
          bit_val  = SYNC_WORD[0];
          idx_d    = IDX_W'(1);
          state_d  = ST_SYNC;
        end
        ST_SYNC: begin
          emit_bit = 1'b1;
          bit_val  = SYNC_WORD[idx_q];
          idx_d    = idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = ST_DATA;
          end
        end
        ST_DATA: begin
          if (st_stuff) emit_stuff = 1'b1;
          else if (idx_q == '0) begin
            if (valid_i) begin
              ready_o  = 1'b1;
              shreg_d  = data_i;
              emit_bit = 1'b1;
              bit_val  = data_i[0];
              idx_d    = IDX_W'(1);
            end else begin
              ln_step = 1'b1;
              ln_cmd  = LN_SE0;
              state_d = ST_EOP;
            end
          end else begin
            emit_bit = 1'b1;
            bit_val  = shreg_q[idx_q];
            idx_d    = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
          end
        end
        ST_EOP: begin
          ln_step = 1'b1;
          if (idx_q == '0) begin
            ln_cmd = LN_SE0;
            idx_d  = IDX_W'(1);
          end else begin
            ln_cmd  = LN_J;
            idx_d   = '0;
            state_d = ST_EOPJ;
          end
        end
        ST_EOPJ: begin
          ln_step = 1'b1;
          ln_cmd  = LN_OFF;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
      if (emit_stuff) begin
        ln_step = 1'b1;
        ln_cmd  = LN_TOGGLE;
      end else if (emit_bit) begin
        ln_step = 1'b1;
        ln_cmd  = bit_val ? LN_HOLD : LN_TOGGLE;
      end
    end
  end

  assign st_step = emit_bit | emit_stuff;
  assign st_one  = emit_bit & bit_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
    end
  end

  usb_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (st_step),
    .clr_i   (st_clr),
    .one_i   (st_one),
    .stuff_o (st_stuff)
  );

  usb_tx_line u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (ln_step),
    .cmd_i       (ln_cmd),
    .low_speed_i (low_speed_i),
    .lvl_o       (ln_lvl),
    .se0_o       (ln_se0),
    .dp_o        (dp_o),
    .dm_o        (dm_o),
    .oe_o        (oe_o)
  );

  AST_READY_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (oe_o && !ln_se0)) else $error("byte taken, pair idle"); // R6
  AST_READY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o) else $error("ready held"); // R6
  AST_STUFF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st_stuff && state_q == ST_DATA) |=> (ln_lvl != $past(ln_lvl))) else $error("stuff missing"); // R4
  AST_NO_READY_STUFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_stuff |-> !ready_o) else $error("ready during stuff"); // R6
endmodule

// File: tb/tb_usb_serial_tx.sv
module tb_usb_serial_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       low_speed_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o, dp_o, dm_o, oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  usb_serial_tx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .low_speed_i(low_speed_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o)
  );

  // {low_speed, byte count, byte2, byte1, byte0}
  localparam int NV = 7;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 2'd1, 24'h0000_00},
    {1'b0, 2'd1, 24'h0000_FF},
    {1'b1, 2'd2, 24'h00_FFFF},
    {1'b0, 2'd2, 24'h00_0FF0},
    {1'b1, 2'd3, 24'h7EA53F},
    {1'b0, 2'd1, 24'h0000_FC},
    {1'b1, 2'd1, 24'h0000_FC}
  };

  logic [2:0] exp_sym [128];
  logic [2:0] obs_sym [128];
  int nexp;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  // {oe, dp, dm}
  function automatic logic [2:0] sym(input bit lvl, input bit se0, input bit oe, input bit ls);
    bit jdp, dp;
    if (se0) return {oe, 2'b00};
    jdp = !ls;
    dp  = lvl ? jdp : !jdp;
    return {oe, dp, !dp};
  endfunction

  task automatic push(input logic [2:0] s);
    exp_sym[nexp] = s;
    nexp++;
  endtask

  task automatic build(input bit ls, input int len, input logic [23:0] dat);
    bit lvl = 1'b1;
    int ones = 0;
    bit b;
    nexp = 0;
    for (int p = 0; p < 8 + 8 * len; p++) begin
      b = (p < 8) ? (p == 7) : dat[p-8];
      if (ones == 6) begin lvl = !lvl; ones = 0; push(sym(lvl, 0, 1, ls)); end
      if (b) ones++;
      else begin lvl = !lvl; ones = 0; end
      push(sym(lvl, 0, 1, ls));
    end
    if (ones == 6) begin lvl = !lvl; push(sym(lvl, 0, 1, ls)); end
    push(sym(lvl, 1, 1, ls));
    push(sym(lvl, 1, 1, ls));
    push(sym(1, 0, 1, ls));
    for (int k = 0; k < 3; k++) push(sym(1, 0, 0, ls));
  endtask

  task automatic run_vec(input int v);
    logic [26:0] e = VEC[v];
    bit ls = e[26];
    int len = int'(e[25:24]);
    logic [23:0] dat = e[23:0];
    int bi = 0, nobs = 0, cyc = 0, bad_rdy = 0, bad_stab = 0;
    bit take;
    logic [2:0] prev;
    string tag;
    build(ls, len, dat);
    @(negedge clk_i);
    low_speed_i = ls;
    while (nobs < nexp) begin
      @(negedge clk_i);
      tick_i  = (cyc % 4 == 0);
      cyc++;
      valid_i = (bi < len);
      data_i  = (bi < len) ? dat[8*bi +: 8] : 8'h00;
      #1;
      take = tick_i && valid_i && ready_o;
      if (!tick_i && ready_o) bad_rdy++;
      prev = {oe_o, dp_o, dm_o};
      @(posedge clk_i);
      #1;
      if (take) bi++;
      if (tick_i) begin obs_sym[nobs] = {oe_o, dp_o, dm_o}; nobs++; end
      else if ({oe_o, dp_o, dm_o} != prev) bad_stab++;
    end
    @(negedge clk_i);
    tick_i = 1'b0;
    valid_i = 1'b0;
    for (int i = 0; i < nexp; i++) begin
      if (i < 8) tag = "R2";
      else if (i < nexp - 6) tag = "R3 R4";
      else tag = "R5 R7";
      check(obs_sym[i] == exp_sym[i], tag, $sformatf("vec %0d symbol %0d", v, i),
            32'(obs_sym[i]), 32'(exp_sym[i]));
    end
    check(bi == len, "R6", $sformatf("vec %0d handshakes", v), bi, len);
    check(bad_rdy == 0, "R6", $sformatf("vec %0d ready off tick", v), bad_rdy, 0);
    check(bad_stab == 0, "R9", $sformatf("vec %0d change off tick", v), bad_stab, 0);
    if (ls) check(obs_sym[0] == 3'b110, "R8", $sformatf("vec %0d low-speed K", v),
                  32'(obs_sym[0]), 32'h6);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check({oe_o, ready_o, dp_o, dm_o} == 4'b0010, "R1", "reset outputs",
          32'({oe_o, ready_o, dp_o, dm_o}), 32'h2);
    rst_ni = 1'b1;
    // idle ticks with nothing offered: pair stays released
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
    #1;
    check(oe_o == 1'b0, "R1", "idle without valid", 32'(oe_o), 0);
    for (int v = 0; v < NV; v++) run_vec(v);
    // byte offered between ticks is not taken early
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 8'h55; tick_i = 1'b0;
    #1;
    check(ready_o == 1'b0, "R6", "ready without tick", 32'(ready_o), 0);
    @(posedge clk_i); #1;
    check(oe_o == 1'b0, "R9", "no start without tick", 32'(oe_o), 0);
    @(negedge clk_i); valid_i = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule